// File: doc/BRIEF.md
# Programmable Countdown Waveform Timer

This block is one timer channel. A 16-bit latch holds the programmed count. On an initialization event the latch value is copied into a down counter, and the counter then steps down on each enabled tick. When it expires, the counter reloads from the latch and the block emits a one-cycle time-out pulse. From these expiries the block builds one of two waveforms on its output pin. In continuous mode the output is a repeating square wave. In single-shot mode it gives exactly one pulse per initialization.

The counter can work as one 16-bit word. It can also work as two cascaded bytes: the low byte counts down and reloads, and the high byte steps once per low-byte wrap. The cascade makes the length of the high phase independent of the whole period. The tick is either every cycle of the system clock or a falling edge of an external clock, and that edge passes through a synchronizer. An active-low gate controls counting in continuous mode, and a falling edge of the gate restarts the count. A 5-bit configuration word selects the clock source, the word width, whether a latch write restarts the count, the waveform and the output enable.

Top module: `wavetimer`

## Requirements
- R1: With cfg[1]=0 (16-bit word), a latched value N gives a time-out every N+1 enabled ticks. At each time-out the counter reloads from the latch, and `timeout` is high for the one cycle after the reloading edge.
- R2: With cfg[1]=1 (cascaded bytes, high byte M = latch[15:8], low byte L = latch[7:0]), the low byte counts down and reloads from L. The high byte decrements once per low-byte wrap. A time-out occurs every (L+1)(M+1) ticks.
- R3: In continuous cascaded mode the pin rises on the tick where the high byte steps to zero and falls at the next time-out. With M=3 and L=4 it is high for 5 ticks out of a 20-tick period.
- R4: In cascaded mode with L=0, a time-out occurs every M+1 ticks.
- R5: In continuous 16-bit mode (cfg[3]=0) the pin goes low at initialization and toggles at every time-out.
- R6: With cfg[3]=1 (single shot), the pin rises at the first time-out after initialization and falls at the second. It then stays low until the next initialization, while the counter keeps reloading and producing time-outs.
- R7: In single-shot mode with a latch value of zero, the pin stays low. It pulses again only after a nonzero value is written to the latch or the mode changes.
- R8: In continuous mode the counter changes only while the synchronized gate is low. In single-shot mode the gate level has no effect on counting.
- R9: A synchronized falling edge of `gate_n` always loads the counter from the latch. A latch write also loads the counter when cfg[2]=0. When cfg[2]=1 a latch write changes only the latch, and the counter keeps counting.
- R10: cfg[0]=1 ticks on every system clock. With cfg[0]=0, a falling edge of `ext_clk` (or of `gate_n`) that is present before system edge k acts on the counter at edge k+3.
- R11: cfg[4] enables the pin. When cfg[4]=0 the pin is low, and the counter and time-outs behave unchanged.
- R12: After reset the latch and the counter read 0xFFFF and the pin and `timeout` are low. While `hold` is high, the counter is held at the latch value and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the internal tick source |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 5 | [0] internal tick, [1] cascaded bytes, [2] latch write does not reload, [3] single shot, [4] pin enable |
| ext_clk | input | 1 | Asynchronous external tick; counts on falling edges |
| gate_n | input | 1 | Asynchronous active-low gate |
| hold | input | 1 | Holds the counter preset and the output low while high |
| latch_wr | input | 1 | Writes latch_din into the latch |
| latch_din | input | 16 | Latch write data |
| wave_pin | output | 1 | Waveform output |
| timeout | output | 1 | One-cycle time-out pulse |
| count | output | 16 | Live counter value |

## Verification
The hardest state to reach is the quiet tail of a single shot. The pulse has finished and the counter keeps reloading, and a zero latch must keep the pin low without masking a later nonzero write. The stimulus sets single-shot mode, writes a short count, waits through many reload periods, and then writes zero followed by a nonzero value. A behavioural model checks every cycle of this. The synchronizer latency is reached by moving the external clock and the gate at chosen cycles and sampling the counter exactly three and four edges later.

// File: rtl/wt_pkg.sv
// Package: shared configuration type and reset constants for the waveform timer.
// Assumes the top-level configuration word is laid out as the struct below, MSB first.
package wt_pkg;

    // Decoded per-channel configuration word (bit 4 down to bit 0).
    typedef struct packed {
        logic out_en;     // bit 4: drive the waveform onto the pin
        logic oneshot;    // bit 3: single-pulse waveform instead of continuous
        logic wr_noinit;  // bit 2: latch writes do not reload the counter
        logic dual;       // bit 1: counter runs as two cascaded bytes
        logic int_clk;    // bit 0: tick on every system clock
    } wt_cfg_t;

    localparam int CFG_W = $bits(wt_cfg_t);

endpackage

// File: rtl/wt_edge_sync.sv
// Module: wt_edge_sync
// Brings an asynchronous input into the clock domain through two flops, then a
// retiming flop and a previous-value flop. It reports the synchronized level and a
// one-cycle falling-edge flag, aligned so that a change seen before edge k can act
// at edge k+3. Assumes the input's idle level equals RST_VAL.
module wt_edge_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic lvl_q;
    logic prev_q;

    // Two-flop synchronizer followed by a retiming and a history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            lvl_q  <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            lvl_q  <= sync_q;
            prev_q <= lvl_q;
        end
    end

    // Edge flag: the level was high one cycle ago and is low now.
    always_comb begin
        lvl  = lvl_q;
        fall = prev_q & ~lvl_q;
    end

endmodule

// File: rtl/wt_down_counter.sv
// Module: wt_down_counter
// Down counter that runs either as one word or as two cascaded half-words. In the
// cascaded form the low half wraps to its reload byte and the high half steps once
// per wrap. It reports expiry (a step taken at zero), which reloads the whole word,
// and the step that takes the high half to zero. Assumes WIDTH is even.
module wt_down_counter #(
    parameter int          WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_CNT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             step,
    input  logic             dual,
    output logic [WIDTH-1:0] cnt,
    output logic             expire,
    output logic             half_step
);

    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;
    logic [HALF-1:0]  lo;
    logic [HALF-1:0]  hi;
    logic [HALF-1:0]  lo_reload;
    logic             lo_zero;
    logic             live_step;

    assign lo        = cnt_q[HALF-1:0];
    assign hi        = cnt_q[WIDTH-1:HALF];
    assign lo_reload = reload_val[HALF-1:0];
    assign lo_zero   = (lo == '0);
    assign live_step = step & ~load;

    // Event decode: expiry for both widths, high-half-to-zero for the cascade.
    always_comb begin
        expire    = live_step & (cnt_q == '0);
        half_step = live_step & dual & lo_zero & (hi == HALF'(1));
    end

    // Next-count selection: load wins, then reload on expiry, then a step.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (expire) begin
            cnt_d = reload_val;
        end else if (step) begin
            if (dual && lo_zero) begin
                cnt_d = {hi - HALF'(1), lo_reload};
            end else begin
                cnt_d = cnt_q - WIDTH'(1);
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == $past(reload_val)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/wt_wave_gen.sv
// Module: wt_wave_gen
// Waveform state machine. Continuous word mode toggles at each expiry. Continuous
// cascaded mode rises when the high half reaches zero and falls at expiry. Single
// shot rises at the first expiry, falls at the second and then stays low until the
// next initialization. Assumes init has priority over every counter event.
module wt_wave_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic expire,
    input  logic half_step,
    input  logic oneshot,
    input  logic dual,
    output logic wave
);

    logic wave_q;
    logic done_q;

    // Waveform level and single-shot completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
            done_q <= 1'b0;
        end else if (init) begin
            wave_q <= 1'b0;
            done_q <= 1'b0;
        end else if (expire) begin
            if (oneshot) begin
                if (!done_q) begin
                    if (wave_q) begin
                        wave_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        wave_q <= 1'b1;
                    end
                end
            end else if (dual) begin
                wave_q <= 1'b0;
            end else begin
                wave_q <= ~wave_q;
            end
        end else if (half_step && !oneshot) begin
            wave_q <= 1'b1;
        end
    end

    assign wave = wave_q;

    AST_INIT_CLEARS_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !wave_q); // R5
    AST_SHOT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot && done_q && !init) |=> !wave_q); // R6

endmodule

// File: rtl/wavetimer.sv
// Module: wavetimer (top)
// One countdown waveform timer channel: a latch, a synchronized external tick and
// gate, the down counter and the waveform generator. Decides the initialization
// events and the counting enable, and applies the output enable and the
// single-shot zero-count mask. Assumes cfg is stable relative to clk.
module wavetimer
    import wt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             ext_clk,
    input  logic             gate_n,
    input  logic             hold,
    input  logic             latch_wr,
    input  logic [CNT_W-1:0] latch_din,
    output logic             wave_pin,
    output logic             timeout,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LATCH_RST = '1;

    wt_cfg_t          cfg_s;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] load_val;
    logic             gate_lvl;
    logic             gate_fall;
    logic             ext_lvl;
    logic             ext_fall;
    logic             tick;
    logic             step;
    logic             init;
    logic             expire;
    logic             half_step;
    logic             wave;
    logic             timeout_q;
    logic             zero_shot;

    assign cfg_s = wt_cfg_t'(cfg);

    // Gate synchronizer and edge detector.
    wt_edge_sync #(.RST_VAL(1'b1)) u_gate_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gate_n),
        .lvl  (gate_lvl),
        .fall (gate_fall)
    );

    // External tick synchronizer and edge detector.
    wt_edge_sync #(.RST_VAL(1'b1)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_clk),
        .lvl  (ext_lvl),
        .fall (ext_fall)
    );

    // Latch register, preset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= LATCH_RST;
        end else if (latch_wr) begin
            latch_q <= latch_din;
        end
    end

    // Tick source, counting enable, initialization events and the load value.
    always_comb begin
        tick      = cfg_s.int_clk ? 1'b1 : ext_fall;
        step      = tick & (cfg_s.oneshot | ~gate_lvl);
        init      = hold | gate_fall | (latch_wr & ~cfg_s.wr_noinit);
        load_val  = latch_wr ? latch_din : latch_q;
        zero_shot = cfg_s.oneshot & (latch_q == '0);
    end

    wt_down_counter #(.WIDTH(CNT_W), .RST_CNT(LATCH_RST)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (init),
        .load_val  (load_val),
        .reload_val(latch_q),
        .step      (step),
        .dual      (cfg_s.dual),
        .cnt       (count),
        .expire    (expire),
        .half_step (half_step)
    );

    wt_wave_gen u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .expire   (expire),
        .half_step(half_step),
        .oneshot  (cfg_s.oneshot),
        .dual     (cfg_s.dual),
        .wave     (wave)
    );

    // Registered time-out pulse, one cycle after the reloading edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= expire;
        end
    end

    assign timeout  = timeout_q;
    assign wave_pin = wave & cfg_s.out_en & ~zero_shot;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_wr && !cfg_s.wr_noinit) |=> count == $past(latch_din)); // R9
    AST_EXT_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall); // R10
    AST_GATE_LEVEL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        gate_fall |-> !gate_lvl && !ext_fall || !gate_lvl); // R9
    AST_EXT_LEVEL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !$past(ext_lvl)); // R10

endmodule

// File: tb/wavetimer_tb.sv
module wavetimer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg = 5'd0;
    logic        ext_clk = 1'b1;
    logic        gate_n = 1'b1;
    logic        hold = 1'b0;
    logic        latch_wr = 1'b0;
    logic [15:0] latch_din = 16'd0;
    logic        wave_pin;
    logic        timeout;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int to_last = 0, to_prev = 0, rise_last = 0, fall_last = 0, pin_hi_cnt = 0;
    bit pin_prev = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    int m_latch, m_cnt, lo, hi, nl;
    bit m_wave, m_done, m_to, glow, gfall, efall, tick, en, init, ex, hs;
    bit gh[4];
    bit eh[4];

    always #4 clk = ~clk;

    wavetimer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .ext_clk(ext_clk), .gate_n(gate_n),
        .hold(hold), .latch_wr(latch_wr), .latch_din(latch_din),
        .wave_pin(wave_pin), .timeout(timeout), .count(count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: one step per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = 16'hFFFF; m_cnt = 16'hFFFF; m_wave = 0; m_done = 0; m_to = 0;
            for (int i = 0; i < 4; i++) begin gh[i] = 1; eh[i] = 1; end
        end else begin
            glow  = !gh[2];
            gfall = gh[3] && !gh[2];
            efall = eh[3] && !eh[2];
            tick  = cfg[0] ? 1'b1 : efall;
            en    = tick && (cfg[3] || glow);
            init  = hold || gfall || (latch_wr && !cfg[2]);
            nl    = latch_wr ? int'(latch_din) : m_latch;
            ex = 0; hs = 0;
            if (init) begin
                m_cnt = nl; m_wave = 0; m_done = 0;
            end else if (en) begin
                lo = m_cnt % 256; hi = m_cnt / 256;
                if (m_cnt == 0) begin
                    ex = 1; m_cnt = m_latch;
                end else if (cfg[1] && lo == 0) begin
                    hi = hi - 1; m_cnt = hi * 256 + (m_latch % 256); hs = (hi == 0);
                end else begin
                    m_cnt = m_cnt - 1;
                end
                if (ex) begin
                    if (cfg[3]) begin
                        if (!m_done) begin
                            if (m_wave) begin m_wave = 0; m_done = 1; end
                            else m_wave = 1;
                        end
                    end else if (cfg[1]) m_wave = 0;
                    else m_wave = !m_wave;
                end else if (hs && !cfg[3]) m_wave = 1;
            end
            m_to = ex; m_latch = nl;
            gh[3] = gh[2]; gh[2] = gh[1]; gh[1] = gh[0]; gh[0] = gate_n;
            eh[3] = eh[2]; eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = ext_clk;
        end
    end

    // Per-cycle comparison and event recording, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(count == 16'(m_cnt), "R1", "model count", count, m_cnt);
            check(timeout == m_to, "R1", "model timeout", timeout, m_to);
            check(wave_pin == (m_wave && cfg[4] && !(cfg[3] && m_latch == 0)),
                  "R5", "model pin", wave_pin, m_wave);
            if (timeout) begin to_prev = to_last; to_last = cyc; end
            if (wave_pin && !pin_prev) rise_last = cyc;
            if (!wave_pin && pin_prev) fall_last = cyc;
            if (wave_pin) pin_hi_cnt++;
            pin_prev = wave_pin;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_latch(input logic [15:0] v);
        @(negedge clk); latch_wr = 1'b1; latch_din = v;
        @(negedge clk); latch_wr = 1'b0;
    endtask

    initial begin
        int d, c0, mark;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        check(count == 16'hFFFF, "R12", "reset count", count, 16'hFFFF);
        check(wave_pin == 1'b0, "R12", "reset pin", wave_pin, 0);
        check(timeout == 1'b0, "R12", "reset timeout", timeout, 0);

        // R1 R5: continuous word mode, N=5
        cfg = 5'h11; gate_n = 1'b0;
        wr_latch(16'd5);
        wait_n(40);
        check(to_last - to_prev == 6, "R1", "timeout interval", to_last - to_prev, 6);
        d = rise_last - fall_last; if (d < 0) d = -d;
        check(d == 6, "R5", "toggle spacing", d, 6);

        // R2 R3: cascaded, M=3 L=4
        cfg = 5'h13;
        wr_latch(16'h0304);
        wait_n(70);
        check(to_last - to_prev == 20, "R2", "cascade interval", to_last - to_prev, 20);
        d = fall_last - rise_last; if (d < 0) d += 20;
        check(d == 5, "R3", "cascade high time", d, 5);

        // R4: cascaded with L=0, M=3
        wr_latch(16'h0300);
        wait_n(30);
        check(to_last - to_prev == 4, "R4", "L zero interval", to_last - to_prev, 4);

        // R6: single shot with N=3
        cfg = 5'h19;
        wr_latch(16'd3);
        pin_hi_cnt = 0; mark = cyc;
        wait_n(40);
        check(pin_hi_cnt == 4, "R6", "single pulse width", pin_hi_cnt, 4);
        check(wave_pin == 1'b0, "R6", "pin after pulse", wave_pin, 0);
        check(to_last > mark + 30, "R6", "counter still recycles", to_last, mark + 30);

        // R7: single shot with zero count, then nonzero
        wr_latch(16'd0);
        pin_hi_cnt = 0;
        wait_n(20);
        check(pin_hi_cnt == 0, "R7", "zero count pin high cycles", pin_hi_cnt, 0);
        wr_latch(16'd2);
        pin_hi_cnt = 0;
        wait_n(20);
        check(pin_hi_cnt == 3, "R7", "pulse after nonzero write", pin_hi_cnt, 3);

        // R8: gate level stops continuous counting, not single shot
        cfg = 5'h11;
        wr_latch(16'h1000);
        wait_n(5);
        gate_n = 1'b1;
        wait_n(5);
        c0 = count;
        wait_n(10);
        check(count == 16'(c0), "R8", "count with gate high", count, c0);
        cfg = 5'h19;
        c0 = count;
        wait_n(5);
        check(count != 16'(c0), "R8", "single shot ignores gate", count, c0 - 5);

        // R9: gate falling edge reloads; write without reload when cfg[2]=1
        cfg = 5'h11;
        gate_n = 1'b0;
        wait_n(4);
        check(count == 16'h1000, "R9", "gate fall reload", count, 16'h1000);
        cfg = 5'h15;
        wr_latch(16'h0050);
        check(count > 16'h0100, "R9", "write without reload", count, 16'h0FFD);

        // R10: external tick acts at the fourth edge
        cfg = 5'h10;
        wr_latch(16'd10);
        wait_n(6);
        ext_clk = 1'b0;
        wait_n(3);
        check(count == 16'd10, "R10", "count before sync delay", count, 10);
        wait_n(1);
        check(count == 16'd9, "R10", "count after sync delay", count, 9);
        ext_clk = 1'b1;
        wait_n(6);

        // R11: pin disabled, counter unchanged
        cfg = 5'h01;
        wr_latch(16'd1);
        pin_hi_cnt = 0;
        wait_n(20);
        check(pin_hi_cnt == 0, "R11", "pin disabled", pin_hi_cnt, 0);
        check(to_last - to_prev == 2, "R11", "timeouts continue", to_last - to_prev, 2);

        // R12: hold keeps preset
        cfg = 5'h11;
        hold = 1'b1;
        wait_n(3);
        check(count == 16'd1, "R12", "hold preset", count, 1);
        check(wave_pin == 1'b0, "R12", "hold pin low", wave_pin, 0);
        wait_n(5);
        check(count == 16'd1, "R12", "hold still preset", count, 1);
        hold = 1'b0;
        wait_n(10);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule